// File: doc/BRIEF.md
# Partitioned Round-Robin Ready Selector

This block chooses one ready operand-collector slot per cycle for a dispatch stage. Each of `N` slots raises a ready bit. The block answers in the same cycle with a valid flag, the index of the chosen slot and a one-hot copy of that choice. The downstream stage raises `accept` when it takes the offered slot. Only an accepted grant moves the rotation state, and that update happens on the next clock edge.

A static mode input selects one of two behaviours. In shared mode, a single rotating pointer covers all `N` slots. In partitioned mode, the slots are cut into `S` equal contiguous groups, one per issue scheduler. Each group rotates on its own pointer, and a lower-numbered group always wins over a higher one. The mode must stay constant between resets. Elaboration fails unless `N` is a whole multiple of `S` and `N >= S`.

Top module: `slot_grant_arbiter`

## Requirements
- R1: When no ready bit is set, `gnt_valid` is 0 and `gnt_onehot` is all zero.
- R2: When any ready bit is set, `gnt_valid` is 1 in the same cycle, and the slot named by `gnt_idx` is a ready slot.
- R3: In shared mode (`part_mode`=0), the grant is the first ready slot found by scanning upward from one past the last accepted slot, wrapping modulo N. After reset the pointer holds slot 0, so the first scan starts at slot 1.
- R4: In partitioned mode (`part_mode`=1), group g holds slots g*N/S through (g+1)*N/S-1. The grant comes from the lowest-numbered group that has any ready slot.
- R5: In partitioned mode, the winning group grants its first ready slot scanning from one past that group's last accepted slot, wrapping inside the group. After reset each group's pointer holds the group's lowest slot.
- R6: A pointer changes only at a clock edge where both `gnt_valid` and `accept` are 1. If a grant is not accepted, the next cycle offers the same slot for the same ready bits.
- R7: In partitioned mode, an accepted grant updates only the pointer of the group that holds the granted slot. Other groups keep their rotation position.
- R8: While `gnt_valid` is 1, `gnt_onehot` has exactly the bit at position `gnt_idx` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| part_mode | input | 1 | 0 = one shared rotation, 1 = per-group rotation; static between resets |
| slot_ready | input | N | Ready bit per collector slot |
| accept | input | 1 | Dispatch takes the offered grant this cycle |
| gnt_valid | output | 1 | A slot is offered |
| gnt_idx | output | $clog2(N) | Index of the offered slot |
| gnt_onehot | output | N | One-hot form of the offered slot |

## Verification
The grant outputs are combinational, so each one is due in the same cycle as the ready vector that produces it. The bench drives inputs on the falling edge and samples two nanoseconds later, well before the next rising edge. An accepted grant affects only the following cycle's choice, because the pointer register loads on the rising edge in between. Every table row therefore checks the grant for its own inputs, and its expected value already includes the pointer moves made by the accepted rows before it. The hold test leaves `accept` low for several cycles, then raises it once and expects the choice to advance exactly one cycle later.

// File: rtl/csel_pkg.sv
package csel_pkg;
  // Width of an index field able to name n entries (at least one bit).
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/csel_rr_pick.sv
module csel_rr_pick
  import csel_pkg::*;
#(
  parameter int unsigned W  = 2,
  parameter int unsigned PW = idx_w(W)
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] last,
  output logic          found,
  output logic [PW-1:0] pick
);
  // Scan from last+1 upward with wrap; descending loop so the nearest hit wins.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int unsigned k = W; k >= 1; k--) begin
      int unsigned c;
      c = (32'(last) + k) % W;
      if (req[c]) begin
        found = 1'b1;
        pick  = PW'(c);
      end
    end
  end
endmodule

// File: rtl/csel_ptr_reg.sv
module csel_ptr_reg #(
  parameter int unsigned PW      = 3,
  parameter logic [PW-1:0] RST_V = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] nxt,
  output logic [PW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_V;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/slot_grant_arbiter.sv
module slot_grant_arbiter
  import csel_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned S = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 part_mode,
  input  logic [N-1:0]         slot_ready,
  input  logic                 accept,
  output logic                 gnt_valid,
  output logic [idx_w(N)-1:0]  gnt_idx,
  output logic [N-1:0]         gnt_onehot
);
  localparam int unsigned G  = N / S;
  localparam int unsigned IW = idx_w(N);
  localparam int unsigned LW = idx_w(G);
  localparam int unsigned SW = idx_w(S);

  if ((N % S) != 0 || N < S) begin : g_bad_cfg
    $error("slot_grant_arbiter: N must be a multiple of S and not below it");
  end

  // ---------------- shared rotation ----------------
  logic [IW-1:0] glb_ptr, glb_pick;
  logic          glb_found, glb_en;

  csel_rr_pick #(.W(N), .PW(IW)) u_glb_pick (
    .req(slot_ready), .last(glb_ptr), .found(glb_found), .pick(glb_pick)
  );

  // ---------------- per-group rotation ----------------
  logic [LW-1:0]   grp_ptr  [S];
  logic [LW-1:0]   grp_pick [S];
  logic [S-1:0]    grp_found, grp_en;
  logic [S*LW-1:0] grp_ptr_flat;

  for (genvar g = 0; g < S; g++) begin : g_grp
    csel_rr_pick #(.W(G), .PW(LW)) u_pick (
      .req(slot_ready[g*G +: G]), .last(grp_ptr[g]),
      .found(grp_found[g]), .pick(grp_pick[g])
    );
    csel_ptr_reg #(.PW(LW), .RST_V('0)) u_ptr (
      .clk(clk), .rst_n(rst_n), .en(grp_en[g]),
      .nxt(grp_pick[g]), .q(grp_ptr[g])
    );
    assign grp_ptr_flat[g*LW +: LW] = grp_ptr[g];
  end

  // Fixed priority across groups: lowest group with a hit wins.
  logic          part_found;
  logic [SW-1:0] part_grp;
  logic [IW-1:0] part_idx;
  always_comb begin
    part_found = 1'b0;
    part_grp   = '0;
    part_idx   = '0;
    for (int g = S - 1; g >= 0; g--) begin
      if (grp_found[g]) begin
        part_found = 1'b1;
        part_grp   = SW'(g);
        part_idx   = IW'(g * G) + IW'(grp_pick[g]);
      end
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    gnt_valid  = part_mode ? part_found : glb_found;
    gnt_idx    = part_mode ? part_idx   : glb_pick;
    gnt_onehot = '0;
    for (int unsigned i = 0; i < N; i++)
      gnt_onehot[i] = gnt_valid && (gnt_idx == IW'(i));
  end

  // ---------------- next-state enables ----------------
  logic take;
  always_comb begin
    take   = gnt_valid & accept;
    glb_en = take & ~part_mode;
    for (int unsigned g = 0; g < S; g++)
      grp_en[g] = take & part_mode & (part_grp == SW'(g));
  end

  csel_ptr_reg #(.PW(IW), .RST_V('0)) u_glb_ptr (
    .clk(clk), .rst_n(rst_n), .en(glb_en), .nxt(glb_pick), .q(glb_ptr)
  );

  // ---------------- assertions ----------------
  logic [N-1:0] below_mask;
  always_comb
    for (int unsigned i = 0; i < N; i++)
      below_mask[i] = (i / G) < (32'(gnt_idx) / G);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(|slot_ready) |-> (!gnt_valid && gnt_onehot == '0));

  p_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_ready) |-> (gnt_valid && slot_ready[gnt_idx]));

  p_lowgrp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (part_mode && gnt_valid) |-> ((slot_ready & below_mask) == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_valid && accept) |=> ($stable(glb_ptr) && $stable(grp_ptr_flat)));

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ($countones(gnt_onehot) == 1 && gnt_onehot[gnt_idx]));
endmodule

// File: tb/sim_slot_grant_arbiter.sv
module sim_slot_grant_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       part_mode;
  logic [7:0] slot_ready;
  logic       accept;
  logic       gnt_valid;
  logic [2:0] gnt_idx;
  logic [7:0] gnt_onehot;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  slot_grant_arbiter #(.N(8), .S(4)) u0 (
    .clk(clk), .rst_n(rst_n), .part_mode(part_mode), .slot_ready(slot_ready),
    .accept(accept), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx),
    .gnt_onehot(gnt_onehot)
  );

  // Row fields: {reset_first, mode, ready[7:0], accept, exp_valid, exp_idx[2:0]}
  // Groups in partitioned mode: {0,1} {2,3} {4,5} {6,7}.
  localparam int NV = 21;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,1'b0,8'h00,1'b1,1'b0,3'd0},  // R1 nothing ready
    {1'b0,1'b0,8'hFF,1'b1,1'b1,3'd1},  // R3 first scan starts at 1
    {1'b0,1'b0,8'hFF,1'b0,1'b1,3'd2},  // R3 not accepted
    {1'b0,1'b0,8'hFF,1'b1,1'b1,3'd2},  // R6 same slot re-offered
    {1'b0,1'b0,8'h01,1'b1,1'b1,3'd0},  // R3 wrap to 0
    {1'b0,1'b0,8'h81,1'b1,1'b1,3'd7},
    {1'b0,1'b0,8'h81,1'b1,1'b1,3'd0},  // R3 wrap past N-1
    {1'b0,1'b0,8'h10,1'b1,1'b1,3'd4},
    {1'b0,1'b0,8'h10,1'b1,1'b1,3'd4},  // R3 only the last-granted slot
    {1'b1,1'b1,8'hFF,1'b1,1'b1,3'd1},  // R5 group 0 from its lowest slot
    {1'b0,1'b1,8'hFF,1'b1,1'b1,3'd0},  // R5 wrap inside group 0
    {1'b0,1'b1,8'hFC,1'b1,1'b1,3'd3},  // R4 group 1 wins
    {1'b0,1'b1,8'hFC,1'b0,1'b1,3'd2},
    {1'b0,1'b1,8'hF0,1'b1,1'b1,3'd5},  // R4 group 2 wins
    {1'b0,1'b1,8'h0C,1'b1,1'b1,3'd2},  // R7 group 1 untouched by row above
    {1'b0,1'b1,8'h30,1'b1,1'b1,3'd4},
    {1'b0,1'b1,8'h40,1'b1,1'b1,3'd6},
    {1'b0,1'b1,8'hC0,1'b1,1'b1,3'd7},
    {1'b0,1'b1,8'h03,1'b1,1'b1,3'd1},  // R7 group 0 kept its place
    {1'b0,1'b1,8'h00,1'b1,1'b0,3'd0},  // R1
    {1'b0,1'b1,8'h82,1'b1,1'b1,3'd1}   // R4 group 0 beats group 3
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; part_mode = mode; slot_ready = '0; accept = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; part_mode = 1'b0; slot_ready = '0; accept = 1'b0;
    // Reset state checks (R1, R3): pointer at slot 0 while held in reset.
    #12;
    chk(gnt_valid == 1'b0, "R1 reset valid", int'(gnt_valid), 0);
    chk(gnt_onehot == 8'h00, "R1 reset onehot", int'(gnt_onehot), 0);
    slot_ready = 8'hFF; #1;
    chk(gnt_idx == 3'd1, "R3 reset pointer", int'(gnt_idx), 1);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] row;
      row = VEC[i];
      if (row[14]) do_reset(row[13]);
      @(negedge clk);
      part_mode = row[13]; slot_ready = row[12:5]; accept = row[4];
      #2;
      chk(gnt_valid == row[3], (row[12:5] == 0) ? "R1 valid" : "R2 valid",
          int'(gnt_valid), int'(row[3]));
      if (row[3]) begin
        chk(gnt_idx == row[2:0], row[13] ? "R4/R5/R7 index" : "R3 index",
            int'(gnt_idx), int'(row[2:0]));
        chk(row[5 + gnt_idx] == 1'b1, "R2 granted slot ready", int'(gnt_idx), -1);
        chk(gnt_onehot == (8'h01 << row[2:0]), "R8 onehot",
            int'(gnt_onehot), int'(8'h01 << row[2:0]));
      end else begin
        chk(gnt_onehot == 8'h00, "R1 onehot", int'(gnt_onehot), 0);
      end
    end

    // R6: no accept holds the group 1 pointer at slot 2, so slot 3 repeats.
    do_reset(1'b1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      slot_ready = 8'h0C; accept = 1'b0;
      #2;
      chk(gnt_idx == 3'd3, "R6 hold", int'(gnt_idx), 3);
    end
    @(negedge clk); accept = 1'b1; #2;
    chk(gnt_idx == 3'd3, "R6 accept cycle", int'(gnt_idx), 3);
    @(negedge clk); accept = 1'b0; #2;
    chk(gnt_idx == 3'd2, "R6 advance after accept", int'(gnt_idx), 2);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule